// File: doc/BRIEF.md
# Indexed RTC Register Access Port

This block sits between a host byte bus and the register file of a real-time clock with battery-backed CMOS storage. The host reaches the registers indirectly: it first writes an address to an index port, then reads or writes the chosen byte through the matching data port. There are two such pairs. Bus offsets 0 and 1 serve the lower bank. Offsets 2 and 3 serve the upper bank, which holds addresses 128 to 255; its index is the address minus 128.

The lower bank holds the time and alarm byte slots, four control registers and general storage. The host writes the time slots, and the counters outside the block read them. The control registers are at indices 10 to 13:
- A sets the divider and the periodic rate, and its top bit shows update-in-progress.
- B holds the mode and interrupt enable bits.
- C collects the event flags and clears when read.
- D reports that RAM and time are valid.

The timekeeping counters and the periodic rate generator are outside the block. They reach it through single-cycle event strobes and status inputs. The block drives one active-high interrupt line.

Top module: `rtc_index_port`

## Requirements
- R1: Writing offset 0 loads the lower index. Accesses at offset 1 read or write the lower-bank byte at that index. The index keeps its value across data accesses, so repeated data reads return the same byte.
- R2: Offsets 2 and 3 are the index and data ports of a separate upper bank. The same index value selects different storage in each bank, and index 127 (address 255) is reachable.
- R3: Lower indices 0 to 9 (seconds, seconds alarm, minutes, minutes alarm, hours, hours alarm, day of week, day of month, month, year) and indices 14 to 127 read back what was last written.
- R4: Register A (index 10) bit 7 reads `uip_in`, and writes to that bit are ignored. Bits 6:0 are read and write. `div_sel` shows bits 6:4 and `rate_sel` shows bits 3:0.
- R5: Register B (index 11) is read and write, and `ctrl_b` shows its contents. Bit 7 halts updates. Bit 6 enables the periodic interrupt, bit 5 the alarm interrupt and bit 4 the update-ended interrupt. Bit 3 enables the square wave, bit 2 selects binary, bit 1 selects 24-hour mode and bit 0 enables DST.
- R6: Register C (index 12) bit 6 is set by `tick_periodic`, bit 5 by `evt_alarm` and bit 4 by `evt_update`, whatever the enables. Bits 3:0 read zero. Host writes to C are ignored.
- R7: C bit 7 and `irq` are high exactly when some flag in C bits 6:4 is set and the matching B bit 6:4 is set.
- R8: A data read of C returns its current value and clears all its flags at the end of that cycle, which drops `irq`.
- R9: An event that arrives in the same cycle as a C read is set after the clear. The read itself returns the value from before the event.
- R10: Register D (index 13) reads bit 7 = `vrt_in` and bits 6:0 = 0, and it ignores writes.
- R11: After reset, both indices, register A, register B and the flags of C are zero, and `irq` is low.
- R12: A read of an index port returns that index, zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe, one per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | 2 | Port offset: 0/1 lower index/data, 2/3 upper index/data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current access |
| tick_periodic | input | 1 | Periodic-rate tick strobe |
| evt_alarm | input | 1 | Alarm-match strobe |
| evt_update | input | 1 | Update-ended strobe |
| uip_in | input | 1 | Update-in-progress status |
| vrt_in | input | 1 | RAM and time valid status |
| irq | output | 1 | Active-high interrupt |
| ctrl_b | output | 8 | Register B contents |
| rate_sel | output | 4 | Periodic rate select (A bits 3:0) |
| div_sel | output | 3 | Divider select (A bits 6:4) |

## Verification
Some properties are checked on every cycle. A read of C with no event leaves the flags clear. Every event strobe leaves its flag set, even during a read. The flags hold when there is neither an event nor a read. `irq` never rises without some enable set. Each index holds unless its index port is written. The bench's scenarios cover what needs a particular byte value. Its scenarios show separation of the banks, masking of the read-only A bit, ignored writes to C and D, and the value returned by a read that coincides with an event.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // bus offsets
  localparam logic [1:0] OFS_LO_IDX = 2'd0;
  localparam logic [1:0] OFS_LO_DAT = 2'd1;
  localparam logic [1:0] OFS_HI_IDX = 2'd2;
  localparam logic [1:0] OFS_HI_DAT = 2'd3;

  // control register slots in the lower bank
  localparam int CTRL_FIRST = 10;
  localparam int CTRL_LAST  = 13;

  typedef enum logic [1:0] {
    SEL_A = 2'd0,
    SEL_B = 2'd1,
    SEL_C = 2'd2,
    SEL_D = 2'd3
  } ctrl_sel_e;

  // flag vector order: [2]=periodic, [1]=alarm, [0]=update-ended
  localparam int FLAG_N = 3;

  function automatic logic is_ctrl_idx(input int unsigned idx);
    return (idx >= CTRL_FIRST) && (idx <= CTRL_LAST);
  endfunction

  function automatic ctrl_sel_e ctrl_sel_of(input int unsigned idx);
    int unsigned d;
    d = idx - CTRL_FIRST;
    return ctrl_sel_e'(d[1:0]);
  endfunction

  // summary: any raised flag whose enable is set
  function automatic logic irq_summary(input logic [FLAG_N-1:0] flags,
                                       input logic [FLAG_N-1:0] enables);
    return |(flags & enables);
  endfunction

  function automatic byte_t flag_byte(input logic summary,
                                      input logic [FLAG_N-1:0] flags);
    return {summary, flags, 4'b0000};
  endfunction
endpackage

// File: rtl/rtc_index_regs.sv
module rtc_index_regs
  import rtc_port_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int IDX_W     = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_BANKS-1:0]            idx_we,
  input  byte_t                           wdata,
  output logic [NUM_BANKS-1:0][IDX_W-1:0] idx_q
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_idx
    always_ff @(posedge clk) begin
      if (!rst_n)         idx_q[b] <= '0;
      else if (idx_we[b]) idx_q[b] <= wdata[IDX_W-1:0];
    end

    // R1: an index changes only through its own index port
    assert_idx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_we[b] |=> $stable(idx_q[b]));
  end
endmodule

// File: rtl/rtc_ram_bank.sv
module rtc_ram_bank
  import rtc_port_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  byte_t         wdata,
  output byte_t         rdata
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_we,
  input  logic        acc_rd,
  input  ctrl_sel_e   sel,
  input  byte_t       wdata,
  input  logic        tick_periodic,
  input  logic        evt_alarm,
  input  logic        evt_update,
  input  logic        uip_in,
  input  logic        vrt_in,
  output byte_t       rdata,
  output byte_t       ctrl_b,
  output logic [3:0]  rate_sel,
  output logic [2:0]  div_sel,
  output logic        irq
);
  logic [6:0]        reg_a;
  byte_t             reg_b;
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] evt_vec;
  logic              rd_c;
  logic              irqf;

  assign evt_vec = {tick_periodic, evt_alarm, evt_update};
  assign rd_c    = acc_rd && (sel == SEL_C);
  assign irqf    = irq_summary(flags, reg_b[6:4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else if (acc_we) begin
      case (sel)
        SEL_A:   reg_a <= wdata[6:0];
        SEL_B:   reg_b <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (rd_c ? '0 : flags) | evt_vec;
  end

  always_comb begin
    case (sel)
      SEL_A:   rdata = {uip_in, reg_a};
      SEL_B:   rdata = reg_b;
      SEL_C:   rdata = flag_byte(irqf, flags);
      default: rdata = {vrt_in, 7'd0};
    endcase
  end

  assign ctrl_b   = reg_b;
  assign rate_sel = reg_a[3:0];
  assign div_sel  = reg_a[6:4];
  assign irq      = irqf;

  // R8: a read with no coincident event leaves no flag behind
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && (evt_vec == '0)) |=> (flags == '0));

  // R9: every arriving event is recorded, even during a read
  assert_event_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((flags & $past(evt_vec)) == $past(evt_vec)));

  // R6: flags move only on events or reads of C
  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_c && (evt_vec == '0)) |=> $stable(flags));

  // R7: the interrupt needs at least one enable
  assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_b[6:4] != 3'b000));
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_port_pkg::*;
#(
  parameter int BANK_DEPTH = 128,
  localparam int IDX_W     = $clog2(BANK_DEPTH),
  localparam int NUM_BANKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_wr,
  input  logic [1:0] bus_ofs,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tick_periodic,
  input  logic       evt_alarm,
  input  logic       evt_update,
  input  logic       uip_in,
  input  logic       vrt_in,
  output logic       irq,
  output logic [7:0] ctrl_b,
  output logic [3:0] rate_sel,
  output logic [2:0] div_sel
);
  // named access events
  logic wr_idx_lo, wr_idx_hi, wr_dat_lo, wr_dat_hi, rd_dat_lo;
  assign wr_idx_lo = bus_en &&  bus_wr && (bus_ofs == OFS_LO_IDX);
  assign wr_idx_hi = bus_en &&  bus_wr && (bus_ofs == OFS_HI_IDX);
  assign wr_dat_lo = bus_en &&  bus_wr && (bus_ofs == OFS_LO_DAT);
  assign wr_dat_hi = bus_en &&  bus_wr && (bus_ofs == OFS_HI_DAT);
  assign rd_dat_lo = bus_en && !bus_wr && (bus_ofs == OFS_LO_DAT);

  logic [NUM_BANKS-1:0][IDX_W-1:0] idx_q;
  logic [NUM_BANKS-1:0]            bank_we;
  byte_t                           bank_rd [NUM_BANKS];
  logic                            lo_is_ctrl;
  ctrl_sel_e                       sel;
  byte_t                           ctrl_rd;

  assign lo_is_ctrl = is_ctrl_idx(int'(idx_q[0]));
  assign sel        = ctrl_sel_of(int'(idx_q[0]));
  assign bank_we    = {wr_dat_hi, wr_dat_lo && !lo_is_ctrl};

  rtc_index_regs #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_idx (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_we ({wr_idx_hi, wr_idx_lo}),
    .wdata  (bus_wdata),
    .idx_q  (idx_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rtc_ram_bank #(.DEPTH(BANK_DEPTH)) u_ram (
      .clk   (clk),
      .we    (bank_we[b]),
      .addr  (idx_q[b]),
      .wdata (bus_wdata),
      .rdata (bank_rd[b])
    );
  end

  rtc_ctrl_regs u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_we        (wr_dat_lo && lo_is_ctrl),
    .acc_rd        (rd_dat_lo && lo_is_ctrl),
    .sel           (sel),
    .wdata         (bus_wdata),
    .tick_periodic (tick_periodic),
    .evt_alarm     (evt_alarm),
    .evt_update    (evt_update),
    .uip_in        (uip_in),
    .vrt_in        (vrt_in),
    .rdata         (ctrl_rd),
    .ctrl_b        (ctrl_b),
    .rate_sel      (rate_sel),
    .div_sel       (div_sel),
    .irq           (irq)
  );

  always_comb begin
    case (bus_ofs)
      OFS_LO_IDX: bus_rdata = BYTE_W'(idx_q[0]);
      OFS_LO_DAT: bus_rdata = lo_is_ctrl ? ctrl_rd : bank_rd[0];
      OFS_HI_IDX: bus_rdata = BYTE_W'(idx_q[1]);
      default:    bus_rdata = bank_rd[1];
    endcase
  end

  // R10: the valid register never shows anything in its low bits
  assert_d_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat_lo && lo_is_ctrl && (sel == SEL_D)) |-> (bus_rdata[6:0] == 7'd0));
endmodule

// File: tb/rtc_index_port_tb.sv
module rtc_index_port_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic bus_en = 0, bus_wr = 0;
  logic [1:0] bus_ofs = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic tick_periodic = 0, evt_alarm = 0, evt_update = 0;
  logic uip_in = 0, vrt_in = 0;
  logic irq;
  logic [7:0] ctrl_b;
  logic [3:0] rate_sel;
  logic [2:0] div_sel;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rtc_index_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_periodic(tick_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .uip_in(uip_in), .vrt_in(vrt_in), .irq(irq), .ctrl_b(ctrl_b),
    .rate_sel(rate_sel), .div_sel(div_sel)
  );

  // monitor: compares each bus read against the scoreboard
  always @(negedge clk) begin
    if (bus_en && !bus_wr) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read ofs %0d got %02h expected %02h", t, bus_ofs, bus_rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [1:0] ofs, input logic [7:0] d);
    @(posedge clk); #1;
    bus_en = 1; bus_wr = 1; bus_ofs = ofs; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] ofs, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    bus_en = 1; bus_wr = 0; bus_ofs = ofs;
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  task automatic check(input logic [7:0] got, input logic [7:0] e, input string t);
    @(negedge clk);
    n_tests++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", t, got, e);
    end
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    case (which)
      0: tick_periodic = 1;
      1: evt_alarm = 1;
      default: evt_update = 1;
    endcase
    @(posedge clk); #1;
    tick_periodic = 0; evt_alarm = 0; evt_update = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset state
    check({7'd0, irq}, 8'h00, "R11 irq after reset");
    check(ctrl_b, 8'h00, "R11 reg B after reset");
    bus_read(2'd0, 8'h00, "R11 lower index after reset");
    bus_read(2'd2, 8'h00, "R11 upper index after reset");
    bus_write(2'd0, 8'd12);
    bus_read(2'd1, 8'h00, "R11 flags after reset");

    // R1 / R3 lower bank storage
    bus_write(2'd0, 8'd3);  bus_write(2'd1, 8'h59);
    bus_write(2'd0, 8'd0);  bus_write(2'd1, 8'h42);
    bus_write(2'd0, 8'd9);  bus_write(2'd1, 8'h99);
    bus_write(2'd0, 8'd32); bus_write(2'd1, 8'hA5);
    bus_write(2'd0, 8'd3);
    bus_read(2'd1, 8'h59, "R1 first data read");
    bus_read(2'd1, 8'h59, "R1 repeated data read");
    bus_read(2'd0, 8'd3,  "R12 lower index readback");
    bus_write(2'd0, 8'd0);  bus_read(2'd1, 8'h42, "R3 seconds slot");
    bus_write(2'd0, 8'd9);  bus_read(2'd1, 8'h99, "R3 year slot");
    bus_write(2'd0, 8'd32); bus_read(2'd1, 8'hA5, "R3 general RAM");

    // R2 upper bank
    bus_write(2'd2, 8'd3);   bus_write(2'd3, 8'h77);
    bus_write(2'd2, 8'd127); bus_write(2'd3, 8'h3C);
    bus_read(2'd2, 8'd127, "R12 upper index readback");
    bus_read(2'd3, 8'h3C, "R2 address 255");
    bus_write(2'd2, 8'd3);   bus_read(2'd3, 8'h77, "R2 upper byte 131");
    bus_write(2'd0, 8'd3);   bus_read(2'd1, 8'h59, "R2 lower byte 3 untouched");

    // R4 register A
    bus_write(2'd0, 8'd10); bus_write(2'd1, 8'hFF);
    bus_read(2'd1, 8'h7F, "R4 A with uip low");
    uip_in = 1;
    bus_read(2'd1, 8'hFF, "R4 A with uip high");
    uip_in = 0;
    check({4'd0, rate_sel}, 8'h0F, "R4 rate_sel");
    check({5'd0, div_sel}, 8'h07, "R4 div_sel");
    bus_write(2'd1, 8'h26);
    bus_read(2'd1, 8'h26, "R4 A rewrite");

    // R5 register B
    bus_write(2'd0, 8'd11); bus_write(2'd1, 8'h40);
    bus_read(2'd1, 8'h40, "R5 B readback");
    check(ctrl_b, 8'h40, "R5 ctrl_b output");

    // R6 / R7 / R8 flags
    pulse(1);
    check({7'd0, irq}, 8'h00, "R7 masked alarm keeps irq low");
    bus_write(2'd0, 8'd12);
    bus_read(2'd1, 8'h20, "R6 alarm flag without summary");
    bus_read(2'd1, 8'h00, "R8 flags cleared by read");
    pulse(0);
    check({7'd0, irq}, 8'h01, "R7 enabled periodic raises irq");
    bus_read(2'd1, 8'hC0, "R7 summary bit with periodic flag");
    check({7'd0, irq}, 8'h00, "R8 irq drops after read");

    // R9 event coincident with read
    @(posedge clk); #1;
    exp_q.push_back(8'h00); tag_q.push_back("R9 read during event returns old value");
    bus_en = 1; bus_wr = 0; bus_ofs = 2'd1; evt_update = 1;
    @(posedge clk); #1;
    bus_en = 0; evt_update = 0;
    bus_read(2'd1, 8'h10, "R9 coincident event retained");
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, 8'h00, "R6 write to C ignored");

    // R10 register D
    vrt_in = 1;
    bus_write(2'd0, 8'd13);
    bus_read(2'd1, 8'h80, "R10 valid bit set");
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, 8'h80, "R10 write ignored");
    vrt_in = 0;
    bus_read(2'd1, 8'h00, "R10 valid bit clear");

    repeat (2) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule